// File: doc/BRIEF.md
# Transmit Transaction Retry Controller

This block sequences one automatic transmit transaction for an IEEE 802.15.4-style radio front end. A start request makes it ask an external CSMA/CA unit for channel access. Once the channel is clear it starts the frame, then reads the outgoing header while the frame is being sent to decide whether an acknowledgement will follow. If no acknowledgement is requested, the transaction ends as soon as the frame has been sent. If one is requested, the block turns the receiver on and waits for a matching ACK. A missing ACK, or an expired external timeout, restarts the whole transaction from channel access, until the programmable retry budget runs out.

Every transaction ends with a one-cycle interrupt and a three-bit result code. The code stays on the port until the next transaction completes. The modem, the backoff timing and the CRC check live outside. The ACK-valid strobe is taken to mean a frame that has already been checked and matched.

Top module: `txn_retry_ctrl`

## Requirements
- R1: While reset is held, and afterwards until a start arrives, busy_o, rx_on_o, irq_o, csma_req_o and tx_start_o are 0 and status_o is 0.
- R2: A start_i pulse in idle raises busy_o and produces a one-cycle csma_req_o in the next cycle. A start_i pulse while busy_o is high has no effect on the transaction.
- R3: csma_fail_i while a channel access attempt is pending ends the transaction with status 3 (channel access failure) and no transmission. This holds on the first attempt and on any retry.
- R4: csma_ok_i while a channel access attempt is pending produces a one-cycle tx_start_o in the next cycle.
- R5: The acknowledge-request flag is bit 5 of the first fc_valid_i octet after tx_start_o. Later octets of the same frame are ignored.
- R6: When the flag is 0, tx_done_i ends the transaction with status 0 (success) and the receiver is never turned on.
- R7: When the flag is 1, rx_on_o rises in the cycle after tx_done_i and stays high until an ACK or a timeout is taken.
- R8: ack_valid_i while rx_on_o is high ends the transaction with status 0. It takes priority over an ack_timeout_i in the same cycle.
- R9: ack_timeout_i while rx_on_o is high, with fewer than max_retries_i retries used, produces a new csma_req_o in the next cycle. A transaction therefore makes at most max_retries_i+1 channel access attempts.
- R10: ack_timeout_i with all retries used ends the transaction with status 5 (no ACK). With max_retries_i = 0 exactly one attempt is made.
- R11: Each transaction raises irq_o for exactly one cycle. busy_o falls and status_o takes its new value at that same edge. status_o does not change again until the next completion.
- R12: In idle, csma_ok_i, csma_fail_i, fc_valid_i, tx_done_i, ack_valid_i and ack_timeout_i have no effect on any output.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Start a transaction (pulse) |
| max_retries_i | input | RETRY_W | Number of retransmissions allowed; hold stable while busy |
| csma_req_o | output | 1 | Request one channel access attempt (pulse) |
| csma_ok_i | input | 1 | Channel found clear (pulse) |
| csma_fail_i | input | 1 | Channel access gave up (pulse) |
| tx_start_o | output | 1 | Begin frame transmission (pulse) |
| fc_valid_i | input | 1 | Outgoing header octet valid |
| fc_octet_i | input | OCTET_W | Outgoing header octet |
| tx_done_i | input | 1 | Frame transmission finished (pulse) |
| rx_on_o | output | 1 | Receiver enabled while waiting for ACK |
| ack_valid_i | input | 1 | Matching ACK received (pulse) |
| ack_timeout_i | input | 1 | ACK wait expired (pulse) |
| busy_o | output | 1 | Transaction in progress |
| irq_o | output | 1 | End-of-transaction interrupt (one cycle) |
| status_o | output | 3 | Result: 0 success, 3 channel access failure, 5 no ACK |

## Verification
A retry counter that is off by one shows at the ports as one csma_req_o pulse too many or too few before the final interrupt. It also changes the result, from success to no-ACK or back. Both become visible at the end of the transaction, some tens of cycles after the first wrong decision. A header flag taken from the wrong octet or bit shows within one cycle of tx_done_i: rx_on_o does not rise, or irq_o fires early. A sequencer stuck in the wrong phase shows within one cycle of the next strobe, as a missing tx_start_o or csma_req_o, a stray response to idle inputs, or an interrupt that lasts more than one cycle.

// File: rtl/txr_pkg.sv
package txr_pkg;

  localparam int STAT_W = 3;

  // Result codes; the values are visible at the status port.
  typedef enum logic [STAT_W-1:0] {
    RES_SUCCESS   = 3'd0,
    RES_CHAN_FAIL = 3'd3,
    RES_NO_ACK    = 3'd5
  } txr_result_e;

  typedef enum logic [1:0] {
    PH_IDLE = 2'd0,
    PH_CCA  = 2'd1,
    PH_SEND = 2'd2,
    PH_WAIT = 2'd3
  } txr_phase_e;

  // A further attempt is allowed while fewer retries than the limit were used.
  function automatic logic retry_allowed(input int unsigned used,
                                         input int unsigned limit);
    return used < limit;
  endfunction

  // Total attempts a transaction may make for a given retry limit.
  function automatic int unsigned attempt_budget(input int unsigned limit);
    return limit + 1;
  endfunction

endpackage

// File: rtl/txr_fc_parser.sv
module txr_fc_parser #(
  parameter int OCTET_W  = 8,
  parameter int FLAG_POS = 5
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               arm_i,
  input  logic               oct_valid_i,
  input  logic [OCTET_W-1:0] oct_i,
  output logic               hdr_seen_o,
  output logic               ack_flag_o
);

  localparam int POS = (FLAG_POS < OCTET_W) ? FLAG_POS : OCTET_W - 1;

  logic seen_q;
  logic flag_q;
  logic take;

  // Only the first octet of a frame carries the flag.
  assign take = oct_valid_i && !seen_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      seen_q <= 1'b0;
      flag_q <= 1'b0;
    end else if (arm_i) begin
      seen_q <= 1'b0;
      flag_q <= 1'b0;
    end else if (take) begin
      seen_q <= 1'b1;
      flag_q <= oct_i[POS];
    end
  end

  assign hdr_seen_o = seen_q;
  assign ack_flag_o = flag_q;

endmodule

// File: rtl/txr_retry_cnt.sv
module txr_retry_cnt #(
  parameter int CNT_W = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clear_i,
  input  logic             bump_i,
  input  logic [CNT_W-1:0] limit_i,
  output logic [CNT_W-1:0] count_o,
  output logic             can_retry_o
);

  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
    end else if (clear_i) begin
      cnt_q <= '0;
    end else if (bump_i) begin
      cnt_q <= cnt_q + 1'b1;
    end
  end

  assign count_o     = cnt_q;
  assign can_retry_o = txr_pkg::retry_allowed(32'(cnt_q), 32'(limit_i));

endmodule

// File: rtl/txr_seq.sv
module txr_seq
  import txr_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        start_i,
  input  logic        csma_ok_i,
  input  logic        csma_fail_i,
  input  logic        tx_done_i,
  input  logic        ack_needed_i,
  input  logic        ack_valid_i,
  input  logic        ack_timeout_i,
  input  logic        can_retry_i,
  output txr_phase_e  phase_o,
  output logic        txn_begin_o,
  output logic        send_begin_o,
  output logic        retry_take_o,
  output logic        csma_req_o,
  output logic        tx_start_o,
  output logic        irq_o,
  output txr_result_e result_o
);

  txr_phase_e  phase_q;
  txr_result_e result_q;
  logic        csma_req_q;
  logic        tx_start_q;
  logic        irq_q;

  // Named events
  logic cca_abort;
  logic send_plain_end;
  logic ack_taken;
  logic wait_expired;
  logic retry_exhausted;
  logic txn_end;

  assign txn_begin_o     = (phase_q == PH_IDLE) && start_i;
  assign cca_abort       = (phase_q == PH_CCA)  && csma_fail_i;
  assign send_begin_o    = (phase_q == PH_CCA)  && csma_ok_i && !csma_fail_i;
  assign send_plain_end  = (phase_q == PH_SEND) && tx_done_i && !ack_needed_i;
  assign ack_taken       = (phase_q == PH_WAIT) && ack_valid_i;
  assign wait_expired    = (phase_q == PH_WAIT) && !ack_valid_i && ack_timeout_i;
  assign retry_take_o    = wait_expired && can_retry_i;
  assign retry_exhausted = wait_expired && !can_retry_i;
  assign txn_end         = cca_abort || send_plain_end || ack_taken || retry_exhausted;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase_q    <= PH_IDLE;
      result_q   <= RES_SUCCESS;
      csma_req_q <= 1'b0;
      tx_start_q <= 1'b0;
      irq_q      <= 1'b0;
    end else begin
      csma_req_q <= txn_begin_o || retry_take_o;
      tx_start_q <= send_begin_o;
      irq_q      <= txn_end;
      unique case (phase_q)
        PH_IDLE: begin
          if (start_i) phase_q <= PH_CCA;
        end
        PH_CCA: begin
          if (csma_fail_i) begin
            phase_q  <= PH_IDLE;
            result_q <= RES_CHAN_FAIL;
          end else if (csma_ok_i) begin
            phase_q <= PH_SEND;
          end
        end
        PH_SEND: begin
          if (tx_done_i) begin
            if (ack_needed_i) begin
              phase_q <= PH_WAIT;
            end else begin
              phase_q  <= PH_IDLE;
              result_q <= RES_SUCCESS;
            end
          end
        end
        PH_WAIT: begin
          if (ack_valid_i) begin
            phase_q  <= PH_IDLE;
            result_q <= RES_SUCCESS;
          end else if (ack_timeout_i) begin
            if (can_retry_i) begin
              phase_q <= PH_CCA;
            end else begin
              phase_q  <= PH_IDLE;
              result_q <= RES_NO_ACK;
            end
          end
        end
        default: phase_q <= PH_IDLE;
      endcase
    end
  end

  assign phase_o    = phase_q;
  assign csma_req_o = csma_req_q;
  assign tx_start_o = tx_start_q;
  assign irq_o      = irq_q;
  assign result_o   = result_q;

endmodule

// File: rtl/txn_retry_ctrl.sv
module txn_retry_ctrl
  import txr_pkg::*;
#(
  parameter int RETRY_W  = 4,
  parameter int OCTET_W  = 8,
  parameter int FLAG_POS = 5
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               start_i,
  input  logic [RETRY_W-1:0] max_retries_i,
  output logic               csma_req_o,
  input  logic               csma_ok_i,
  input  logic               csma_fail_i,
  output logic               tx_start_o,
  input  logic               fc_valid_i,
  input  logic [OCTET_W-1:0] fc_octet_i,
  input  logic               tx_done_i,
  output logic               rx_on_o,
  input  logic               ack_valid_i,
  input  logic               ack_timeout_i,
  output logic               busy_o,
  output logic               irq_o,
  output logic [STAT_W-1:0]  status_o
);

  txr_phase_e       phase;
  txr_result_e      result;
  logic             txn_begin;
  logic             send_begin;
  logic             retry_take;
  logic             can_retry;
  logic             hdr_seen;
  logic             hdr_flag;
  logic             ack_needed;
  logic             oct_take;
  logic [RETRY_W-1:0] retry_cnt;

  // Header octets count only while a frame is being sent.
  assign oct_take   = fc_valid_i && (phase == PH_SEND);
  assign ack_needed = hdr_seen && hdr_flag;

  txr_seq u_seq (
    .clk          (clk),
    .rst_n        (rst_n),
    .start_i      (start_i),
    .csma_ok_i    (csma_ok_i),
    .csma_fail_i  (csma_fail_i),
    .tx_done_i    (tx_done_i),
    .ack_needed_i (ack_needed),
    .ack_valid_i  (ack_valid_i),
    .ack_timeout_i(ack_timeout_i),
    .can_retry_i  (can_retry),
    .phase_o      (phase),
    .txn_begin_o  (txn_begin),
    .send_begin_o (send_begin),
    .retry_take_o (retry_take),
    .csma_req_o   (csma_req_o),
    .tx_start_o   (tx_start_o),
    .irq_o        (irq_o),
    .result_o     (result)
  );

  txr_fc_parser #(
    .OCTET_W (OCTET_W),
    .FLAG_POS(FLAG_POS)
  ) u_parse (
    .clk        (clk),
    .rst_n      (rst_n),
    .arm_i      (send_begin),
    .oct_valid_i(oct_take),
    .oct_i      (fc_octet_i),
    .hdr_seen_o (hdr_seen),
    .ack_flag_o (hdr_flag)
  );

  txr_retry_cnt #(
    .CNT_W(RETRY_W)
  ) u_cnt (
    .clk        (clk),
    .rst_n      (rst_n),
    .clear_i    (txn_begin),
    .bump_i     (retry_take),
    .limit_i    (max_retries_i),
    .count_o    (retry_cnt),
    .can_retry_o(can_retry)
  );

  assign rx_on_o  = (phase == PH_WAIT);
  assign busy_o   = (phase != PH_IDLE);
  assign status_o = result;

endmodule

// File: rtl/txr_checker.sv
module txr_checker #(
  parameter int RETRY_W = 4
) (
  input logic               clk,
  input logic               rst_n,
  input logic               csma_req_o,
  input logic               csma_ok_i,
  input logic               tx_start_o,
  input logic               tx_done_i,
  input logic               rx_on_o,
  input logic               busy_o,
  input logic               irq_o,
  input logic [2:0]         status_o,
  input logic [RETRY_W-1:0] retry_cnt,
  input logic [RETRY_W-1:0] max_retries_i
);

  assert_strobes_exclusive_R11: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({csma_req_o, tx_start_o, irq_o}));

  assert_irq_single_R11: assert property (@(posedge clk) disable iff (!rst_n)
    irq_o |=> (!irq_o && !busy_o));

  assert_status_moves_with_irq_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (status_o != $past(status_o)) |-> irq_o);

  assert_tx_after_clear_R4: assert property (@(posedge clk) disable iff (!rst_n)
    tx_start_o |-> ($past(csma_ok_i) && $past(busy_o)));

  assert_rx_after_send_R7: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rx_on_o) |-> $past(tx_done_i));

  assert_noack_from_wait_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_o && status_o == 3'd5) |-> $past(rx_on_o));

  assert_chanfail_from_cca_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_o && status_o == 3'd3) |-> (!$past(rx_on_o) && $past(busy_o)));

  assert_retry_bounded_R9: assert property (@(posedge clk) disable iff (!rst_n)
    busy_o |-> (retry_cnt <= max_retries_i));

endmodule

bind txn_retry_ctrl txr_checker #(.RETRY_W(RETRY_W)) u_txr_checker (
  .clk          (clk),
  .rst_n        (rst_n),
  .csma_req_o   (csma_req_o),
  .csma_ok_i    (csma_ok_i),
  .tx_start_o   (tx_start_o),
  .tx_done_i    (tx_done_i),
  .rx_on_o      (rx_on_o),
  .busy_o       (busy_o),
  .irq_o        (irq_o),
  .status_o     (status_o),
  .retry_cnt    (retry_cnt),
  .max_retries_i(max_retries_i)
);

// File: tb/txn_retry_ctrl_bench.sv
module txn_retry_ctrl_bench;

  localparam int CLK_PERIOD = 10;
  localparam int WATCHDOG   = 150000;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       start_i = 1'b0;
  logic [3:0] max_retries_i = 4'd0;
  logic       csma_req_o;
  logic       csma_ok_i = 1'b0;
  logic       csma_fail_i = 1'b0;
  logic       tx_start_o;
  logic       fc_valid_i = 1'b0;
  logic [7:0] fc_octet_i = 8'h00;
  logic       tx_done_i = 1'b0;
  logic       rx_on_o;
  logic       ack_valid_i = 1'b0;
  logic       ack_timeout_i = 1'b0;
  logic       busy_o;
  logic       irq_o;
  logic [2:0] status_o;

  int checks = 0;
  int errors = 0;
  int cycles = 0;

  txn_retry_ctrl u_txn_retry_ctrl (
    .clk          (clk),
    .rst_n        (rst_n),
    .start_i      (start_i),
    .max_retries_i(max_retries_i),
    .csma_req_o   (csma_req_o),
    .csma_ok_i    (csma_ok_i),
    .csma_fail_i  (csma_fail_i),
    .tx_start_o   (tx_start_o),
    .fc_valid_i   (fc_valid_i),
    .fc_octet_i   (fc_octet_i),
    .tx_done_i    (tx_done_i),
    .rx_on_o      (rx_on_o),
    .ack_valid_i  (ack_valid_i),
    .ack_timeout_i(ack_timeout_i),
    .busy_o       (busy_o),
    .irq_o        (irq_o),
    .status_o     (status_o)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  always @(posedge clk) begin
    cycles++;
    if (cycles > WATCHDOG) begin
      errors++;
      $display("FAIL watchdog: actual %0d cycles expected below %0d", cycles, WATCHDOG);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic clear_pulses();
    start_i       = 1'b0;
    csma_ok_i     = 1'b0;
    csma_fail_i   = 1'b0;
    fc_valid_i    = 1'b0;
    tx_done_i     = 1'b0;
    ack_valid_i   = 1'b0;
    ack_timeout_i = 1'b0;
  endtask

  // One transaction. fails: number of attempts answered by timeout before an ACK.
  // caf_at: attempt index whose channel access fails (-1 none).
  task automatic txn(input int lim, input int fails, input bit areq,
                     input int caf_at, input bit tie, input bit poke_start);
    int  base;
    int  exp_st;
    int  exp_att;
    int  att = 0;
    int  guard = 0;
    int  rxw = 0;
    int  txph = 0;
    int  got_st = 0;
    bit  fin = 0;
    bit  poked = 0;
    bit  exp_txs = 0;
    bit  exp_rx = 0;
    bit  exp_rq = 0;
    logic [2:0] held;

    base = areq ? ((fails <= lim) ? fails + 1 : lim + 1) : 1;
    if (caf_at >= 0 && caf_at < base) begin
      exp_st  = 3;
      exp_att = caf_at + 1;
    end else begin
      exp_st  = (areq && fails > lim) ? 5 : 0;
      exp_att = base;
    end

    max_retries_i = 4'(lim);
    @(negedge clk);
    start_i = 1'b1;
    @(negedge clk);
    start_i = 1'b0;
    chk("R2 busy after start", int'(busy_o), 1);
    chk("R2 channel request after start", int'(csma_req_o), 1);

    while (!fin && guard < 3000) begin
      guard++;
      if (exp_txs) chk("R4 tx_start after clear channel", int'(tx_start_o), 1);
      if (exp_rx)  chk("R7 receiver on after send", int'(rx_on_o), int'(areq));
      if (exp_rq)  chk("R9 new channel request after timeout", int'(csma_req_o), 1);
      exp_txs = 0; exp_rx = 0; exp_rq = 0;
      clear_pulses();
      if (irq_o) begin
        fin    = 1;
        got_st = int'(status_o);
      end else begin
        if (csma_req_o) begin
          att++;
          if (att - 1 == caf_at) csma_fail_i = 1'b1;
          else begin
            csma_ok_i = 1'b1;
            exp_txs   = 1;
          end
        end
        if (tx_start_o) begin
          fc_valid_i = 1'b1;
          fc_octet_i = areq ? 8'h21 : 8'h41;  // R5 flag in bit 5 of first octet
          txph = 1;
        end else if (txph == 1) begin
          fc_valid_i = 1'b1;
          fc_octet_i = areq ? 8'h41 : 8'h61;  // R5 later octet has the opposite flag
          txph = 2;
        end else if (txph == 2) begin
          tx_done_i = 1'b1;
          txph   = 0;
          exp_rx = 1;
        end
        if (rx_on_o) begin
          rxw++;
          if (poke_start && !poked && rxw == 1) begin
            start_i = 1'b1;
            poked   = 1;
          end
          if (rxw == 2) begin
            if (att - 1 < fails) begin
              ack_timeout_i = 1'b1;
              if (att - 1 < lim) exp_rq = 1;
            end else begin
              ack_valid_i = 1'b1;
              if (tie) ack_timeout_i = 1'b1;  // R8 ACK wins the tie
            end
          end
        end else begin
          rxw = 0;
        end
      end
      if (!fin) @(negedge clk);
    end

    if (!fin) chk("R11 transaction never ended", 0, 1);
    chk("R3 R6 R8 R10 result code", got_st, exp_st);
    chk("R9 R10 attempt count", att, exp_att);
    held = status_o;
    @(negedge clk);
    chk("R11 irq single cycle", int'(irq_o), 0);
    chk("R11 busy low after end", int'(busy_o), 0);
    @(negedge clk);
    @(negedge clk);
    chk("R11 status held", int'(status_o), int'(held));
  endtask

  initial begin
    repeat (2) @(negedge clk);
    chk("R1 reset busy", int'(busy_o), 0);
    chk("R1 reset irq", int'(irq_o), 0);
    chk("R1 reset status", int'(status_o), 0);
    chk("R1 reset rx_on", int'(rx_on_o), 0);
    chk("R1 reset strobes", int'(csma_req_o) + int'(tx_start_o), 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1 idle after reset", int'(busy_o), 0);

    // R12: stray inputs in idle
    for (int k = 0; k < 6; k++) begin
      clear_pulses();
      case (k)
        0: csma_ok_i = 1'b1;
        1: csma_fail_i = 1'b1;
        2: begin fc_valid_i = 1'b1; fc_octet_i = 8'hFF; end
        3: tx_done_i = 1'b1;
        4: ack_valid_i = 1'b1;
        default: ack_timeout_i = 1'b1;
      endcase
      @(negedge clk);
      clear_pulses();
      chk("R12 idle input ignored",
          int'(busy_o) + int'(irq_o) + int'(rx_on_o) + int'(csma_req_o) + int'(tx_start_o) + int'(status_o), 0);
    end

    // R6: no ACK requested, timeouts would not matter
    txn(3, 3, 1'b0, -1, 1'b0, 1'b0);
    // R3: channel access failure on first and later attempts
    for (int c = 0; c < 5; c++) txn(3, 5, 1'b1, c, 1'b0, 1'b0);
    txn(0, 0, 1'b0, 0, 1'b0, 1'b0);
    // R8: ACK and timeout together
    txn(2, 1, 1'b1, -1, 1'b1, 1'b0);
    // R2: start while busy is ignored
    txn(2, 1, 1'b1, -1, 1'b0, 1'b1);
    txn(1, 5, 1'b1, -1, 1'b0, 1'b1);
    // R9 R10: sweep limits and number of missed ACKs
    for (int lim = 0; lim < 16; lim++) begin
      for (int f = 0; f <= lim + 1; f++) txn(lim, f, 1'b1, -1, 1'b0, 1'b0);
    end

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule